// File: doc/BRIEF.md
# UART Modem-Line Flow Controller

This block runs hardware flow control on the modem lines of a UART. It sits beside a serial transmitter and a 16-entry receive FIFO and sees them only through level and strobe signals. On the receive side it watches the FIFO fill level and drives the RTS pin. RTS goes off (high) when the FIFO fills past an upper threshold and comes back on (low) when the FIFO drains to a lower threshold. The pair of thresholds depends on the selected trigger level. The same trigger level also drives a receive-trigger interrupt request. The receiver keeps accepting characters after RTS goes off, so overflow protection beyond that point belongs to the FIFO.

On the transmit side it watches the CTS input from the remote end, after a two-flop synchronizer. A high CTS means the remote buffer is full. The transmitter never has a character cut short: the pause is taken only on the transmitter's character-boundary strobe, which marks the end of a stop bit or an idle transmitter. The pause is dropped as soon as CTS returns low. A rising edge on the synchronized CTS sets a sticky status flag when its interrupt enable is set, and software clears the flag with a pulse. Auto RTS and auto CTS have separate enables. With auto RTS off, the pin follows a software bit.

Top module: `uart_modem_flow`

## Requirements
- R1: After reset, rts_out is 0 (asserted), tx_pause is 0, rx_trig_irq is 0 and cts_chg_flag is 0.
- R2: rx_trig_irq is 1 in the cycle after rx_level is at or above the interrupt threshold of trig_sel (encoding 0,1,2,3 gives 1, 4, 8 and 14 entries), and 0 otherwise.
- R3: With auto_rts_en set, the internal RTS-off state becomes 1 one cycle after rx_level reaches the off threshold (4, 8, 12 and 14 for trig_sel 0 to 3), and rts_out shows that state.
- R4: With auto_rts_en set, the RTS-off state returns to 0 one cycle after rx_level is at or below the on threshold (1, 4, 8 and 10 for trig_sel 0 to 3). Between the two thresholds it holds its value.
- R5: With auto_rts_en clear, rts_out equals sw_rts_off in the same cycle, and the RTS-off state is cleared.
- R6: cts_in passes through two synchronizer flops. With auto_cts_en set and the synchronized CTS high, tx_pause rises only in the cycle after a tx_char_done strobe.
- R7: tx_pause falls one cycle after the synchronized CTS is low or auto_cts_en is clear.
- R8: cts_chg_flag is set one cycle after a 0-to-1 edge of the synchronized CTS while cts_irq_en is set. It stays set until a flag_clr pulse, and a new edge in the same cycle wins over the clear.
- R9: With auto_cts_en clear, CTS has no effect on tx_pause, which stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | LVL_W (5) | Receive FIFO fill level, 0 to FIFO_DEPTH |
| trig_sel | input | 2 | Trigger-level select: 0,1,2,3 for 1, 4, 8, 14 |
| auto_rts_en | input | 1 | Enable hardware RTS control |
| auto_cts_en | input | 1 | Enable hardware CTS control |
| cts_irq_en | input | 1 | Allows a CTS edge to set the status flag |
| sw_rts_off | input | 1 | Software RTS pin value when auto RTS is off |
| cts_in | input | 1 | Asynchronous CTS pin, 1 = remote full |
| tx_char_done | input | 1 | Transmitter character-boundary strobe |
| flag_clr | input | 1 | Clears cts_chg_flag |
| rts_out | output | 1 | RTS pin, 1 = off |
| tx_pause | output | 1 | Tells the transmitter to start no new character |
| rx_trig_irq | output | 1 | Receive-trigger interrupt request |
| cts_chg_flag | output | 1 | Sticky CTS rising-edge status |

## Verification
The bench builds the block with its defaults: a 16-entry FIFO and a two-stage synchronizer. With 16 entries, every row of the threshold table is reachable, including the 14/14/10 row where the interrupt and RTS-off thresholds coincide, as well as the full level of 16. The two-stage synchronizer fixes the CTS-to-pause and CTS-to-flag delays that the behavioural reference model tracks with a short queue. Level ramps and random CTS and strobe patterns push every threshold, the hold zones and the boundary-gated pause through a per-clock comparison.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

    typedef struct packed {
        logic [7:0] irq_at;
        logic [7:0] off_at;
        logic [7:0] on_at;
    } thr_t;

    // Threshold row per trigger select: interrupt, RTS off, RTS back on.
    function automatic thr_t thresholds(input logic [1:0] sel);
        thr_t t;
        case (sel)
            2'd0:    begin t.irq_at = 8'd1;  t.off_at = 8'd4;  t.on_at = 8'd1;  end
            2'd1:    begin t.irq_at = 8'd4;  t.off_at = 8'd8;  t.on_at = 8'd4;  end
            2'd2:    begin t.irq_at = 8'd8;  t.off_at = 8'd12; t.on_at = 8'd8;  end
            default: begin t.irq_at = 8'd14; t.off_at = 8'd14; t.on_at = 8'd10; end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/mfc_rts_hyst.sv
module mfc_rts_hyst #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [1:0]       trig_sel,
    input  logic             auto_rts_en,
    input  logic             sw_rts_off,
    output logic             rts_out,
    output logic             rx_trig_irq
);
    import mfc_pkg::*;

    typedef struct packed {
        logic rts_off;
        logic irq;
    } st_t;

    st_t  st_d, st_q;
    thr_t thr;
    logic [7:0] lvl8;

    always_comb begin
        thr  = thresholds(trig_sel);
        lvl8 = 8'(rx_level);
        st_d = st_q;
        st_d.irq = (lvl8 >= thr.irq_at);
        if (!auto_rts_en) begin
            st_d.rts_off = 1'b0;
        end else if (lvl8 >= thr.off_at) begin
            st_d.rts_off = 1'b1;
        end else if (lvl8 <= thr.on_at) begin
            st_d.rts_off = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rts_out     = auto_rts_en ? st_q.rts_off : sw_rts_off;
    assign rx_trig_irq = st_q.irq;

    assert_rts_off_at_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && auto_rts_en && $past(auto_rts_en) && $past(lvl8 >= thr.off_at))
        |-> rts_out);

    assert_rts_on_at_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && auto_rts_en && $past(auto_rts_en) && $past(lvl8 <= thr.on_at)
         && !$past(lvl8 >= thr.off_at))
        |-> !rts_out);

    assert_irq_follows_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_trig_irq == $past(lvl8 >= thr.irq_at)));

endmodule

// File: rtl/mfc_cts_sync.sv
module mfc_cts_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_in,
    input  logic cts_irq_en,
    input  logic flag_clr,
    output logic cts_sync,
    output logic cts_chg_flag
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
        logic                   flag;
    } st_t;

    st_t  st_d, st_q;
    logic rise;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-2:0], cts_in};
        st_d.prev  = st_q.chain[SYNC_STAGES-1];
        rise       = st_q.chain[SYNC_STAGES-1] && !st_q.prev;
        if (rise && cts_irq_en) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cts_sync     = st_q.chain[SYNC_STAGES-1];
    assign cts_chg_flag = st_q.flag;

    assert_flag_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cts_chg_flag) |-> $past(cts_irq_en));

    assert_flag_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cts_chg_flag) |-> $past(cts_sync));

endmodule

// File: rtl/mfc_tx_gate.sv
module mfc_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_sync,
    input  logic auto_cts_en,
    input  logic tx_char_done,
    output logic tx_pause
);
    typedef struct packed {
        logic pause;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!auto_cts_en || !cts_sync) begin
            st_d.pause = 1'b0;
        end else if (tx_char_done) begin
            st_d.pause = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_pause = st_q.pause;

    assert_pause_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause) |-> $past(tx_char_done));

    assert_pause_needs_auto_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pause |-> $past(auto_cts_en));

    assert_pause_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cts_sync)) |-> !tx_pause);

endmodule

// File: rtl/uart_modem_flow.sv
module uart_modem_flow #(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [1:0]       trig_sel,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             cts_irq_en,
    input  logic             sw_rts_off,
    input  logic             cts_in,
    input  logic             tx_char_done,
    input  logic             flag_clr,
    output logic             rts_out,
    output logic             tx_pause,
    output logic             rx_trig_irq,
    output logic             cts_chg_flag
);
    logic cts_sync;

    mfc_rts_hyst #(.LVL_W(LVL_W)) rts_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_level    (rx_level),
        .trig_sel    (trig_sel),
        .auto_rts_en (auto_rts_en),
        .sw_rts_off  (sw_rts_off),
        .rts_out     (rts_out),
        .rx_trig_irq (rx_trig_irq)
    );

    mfc_cts_sync #(.SYNC_STAGES(SYNC_STAGES)) cts_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cts_in       (cts_in),
        .cts_irq_en   (cts_irq_en),
        .flag_clr     (flag_clr),
        .cts_sync     (cts_sync),
        .cts_chg_flag (cts_chg_flag)
    );

    mfc_tx_gate gate_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cts_sync     (cts_sync),
        .auto_cts_en  (auto_cts_en),
        .tx_char_done (tx_char_done),
        .tx_pause     (tx_pause)
    );

endmodule

// File: tb/uart_modem_flow_tb_top.sv
`timescale 1ns/1ps
module uart_modem_flow_tb_top;
    localparam int LVL_W = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [1:0] trig_sel = '0;
    logic auto_rts_en = 0, auto_cts_en = 0, cts_irq_en = 0, sw_rts_off = 0;
    logic cts_in = 0, tx_char_done = 0, flag_clr = 0;
    logic rts_out, tx_pause, rx_trig_irq, cts_chg_flag;

    int checks = 0, fails = 0, cyc = 0;
    bit strobe_on = 1;

    always #2 clk = ~clk;

    uart_modem_flow dut_i (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .trig_sel(trig_sel),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .cts_irq_en(cts_irq_en),
        .sw_rts_off(sw_rts_off), .cts_in(cts_in), .tx_char_done(tx_char_done),
        .flag_clr(flag_clr), .rts_out(rts_out), .tx_pause(tx_pause),
        .rx_trig_irq(rx_trig_irq), .cts_chg_flag(cts_chg_flag)
    );

    // Reference model, behavioural
    bit m_rts_off, m_irq, m_pause, m_flag;
    bit cts_hist[$] = '{0, 0, 0};

    function automatic int irq_th(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction
    function automatic int off_th(input int s);
        return (s == 0) ? 4 : (s == 1) ? 8 : (s == 2) ? 12 : 14;
    endfunction
    function automatic int on_th(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 10;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rts_off = 0; m_irq = 0; m_pause = 0; m_flag = 0;
            cts_hist = '{0, 0, 0};
        end else begin
            int lvl;
            bit synced, older;
            lvl    = int'(rx_level);
            synced = cts_hist[1];
            older  = cts_hist[0];
            m_irq  = (lvl >= irq_th(trig_sel));
            if (!auto_rts_en) m_rts_off = 0;
            else if (lvl >= off_th(trig_sel)) m_rts_off = 1;
            else if (lvl <= on_th(trig_sel)) m_rts_off = 0;
            if (synced && !older && cts_irq_en) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (!auto_cts_en || !synced) m_pause = 0;
            else if (tx_char_done) m_pause = 1;
            cts_hist.push_back(cts_in);
            void'(cts_hist.pop_front());
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            check("R1 rts", rts_out, 1'b0);
            check("R1 pause", tx_pause, 1'b0);
            check("R1 irq", rx_trig_irq, 1'b0);
            check("R1 flag", cts_chg_flag, 1'b0);
        end else begin
            check(auto_rts_en ? "R3 R4 rts" : "R5 rts", rts_out,
                  auto_rts_en ? m_rts_off : sw_rts_off);
            check("R6 R7 R9 pause", tx_pause, m_pause);
            check("R2 irq", rx_trig_irq, m_irq);
            check("R8 flag", cts_chg_flag, m_flag);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            cyc++;
            tx_char_done = strobe_on && (cyc % 7 == 0);
            flag_clr = 0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1;
        tick(2);
        // R2 R3 R4: ramps through every trigger row
        auto_rts_en = 1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            for (int l = 0; l <= 16; l++) begin rx_level = 5'(l); tick(2); end
            for (int l = 16; l >= 0; l--) begin rx_level = 5'(l); tick(2); end
        end
        // R5: software control of the pin
        auto_rts_en = 0; rx_level = 5'd16;
        for (int i = 0; i < 6; i++) begin sw_rts_off = ~sw_rts_off; tick(3); end
        trig_sel = 2'd3; rx_level = 5'd12; auto_rts_en = 1; tick(4);
        // R6 R7 R8: CTS stop and release
        auto_cts_en = 1; cts_irq_en = 1;
        cts_in = 1; tick(20);
        flag_clr = 1; tick(1);
        tick(3);
        cts_in = 0; tick(10);
        // R9: auto CTS off
        auto_cts_en = 0; cts_in = 1; tick(20);
        cts_in = 0; tick(5);
        // R8: edge without enable
        cts_irq_en = 0; cts_in = 1; tick(8); cts_in = 0; tick(5);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 15) cts_in = ~cts_in;
            if (r % 11 == 0) flag_clr = 1;
            if (r % 23 == 0) auto_cts_en = ~auto_cts_en;
            if (r % 29 == 0) auto_rts_en = ~auto_rts_en;
            if (r % 31 == 0) cts_irq_en = ~cts_irq_en;
            if (r % 37 == 0) trig_sel = 2'($urandom_range(0, 3));
            if (r % 5 == 0) sw_rts_off = ~sw_rts_off;
            if (r < 40) rx_level = 5'($urandom_range(0, 16));
            strobe_on = (r % 3 != 0);
            tick(1);
        end
        tick(3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule